// File: doc/BRIEF.md
# Guarded Control Register Write Sequencer

This block decides whether writes to a small control register behind a byte-oriented serial slave are allowed. The register holds a two-bit watchdog period field and a two-bit power-up delay field. A serial front end, not part of this block, decodes the bus traffic into simple events: an address phase (read or write, and whether the control register is the target), one complete data byte, a stop condition, and a periodic timing tick. The block answers each address phase and each data byte with a registered acknowledge decision. It also holds two volatile enable latches that must be set, in order, before the stored bits can change.

An update takes three separate write transactions. The first uses byte 02h to set the write-enable latch. The second uses byte 06h to set the register-write-enable latch. The third carries the new field values. That third write starts a nonvolatile update, modelled by flops and a tick counter. While the update runs, the block refuses every address phase, so the host can poll until the update is complete.

The state machine has seven states:
- ST_IDLE: no transaction.
- ST_CTRL_W: a control write has been addressed.
- ST_HOLD: one data byte has been accepted and is waiting for the stop.
- ST_ABORT: the write was refused; the block waits for a stop or a new address.
- ST_MEM_W: a write to another target is open.
- ST_READ: a read transaction is open.
- ST_NV_BUSY: an update is in progress.

Transitions:
- From any state except ST_NV_BUSY, an address phase moves to ST_READ, ST_CTRL_W or ST_MEM_W, according to its direction and target.
- In ST_CTRL_W, an accepted byte moves to ST_HOLD. A refused byte moves to ST_ABORT.
- In ST_HOLD, a second byte moves to ST_ABORT.
- A stop in ST_HOLD commits the held byte. It moves to ST_NV_BUSY if the byte is a field update, and to ST_IDLE otherwise.
- A stop in any other transaction state returns to ST_IDLE.
- ST_NV_BUSY returns to ST_IDLE after NV_TICKS ticks.

Top module: `ctrl_guard_seq`

## Requirements
- R1: After power-on reset (por_n low), wd_o is 11, pup_o is 01, busy_o is 0, and both enable latches are clear.
- R2: A soft reset (rst_n low) clears both enable latches and returns the sequencer to ST_IDLE. wd_o and pup_o keep their values.
- R3: While the write-enable latch is clear, a control data byte of 02h is acknowledged and, once the stop arrives, sets that latch. Any other control data byte is not acknowledged and has no effect.
- R4: With the write-enable latch set, byte 06h sets the register-write-enable latch. A later field byte with bits 4..2 = 0 and bit 1 = 1 is acknowledged. At its stop the byte loads wd_o = {bit6, bit5} and pup_o = {bit7, bit0}, clears the register-write-enable latch, and raises busy_o.
- R5: With the register-write-enable latch set, a field byte with bit 2 = 1 (for example 06h) leaves wd_o and pup_o unchanged, does not raise busy_o, and keeps the latch set. The sequence 02h, 06h, 02h therefore stores all zeros.
- R6: A second data byte in one control write is not acknowledged, and the whole write is dropped.
- R7: A control write that ends with a stop before any data byte changes nothing.
- R8: While busy_o is high, every address phase gets ack_vld_o = 1 with ack_o = 0. busy_o falls on the NV_TICKS-th tick after the commit.
- R9: With wp_i high, a write data byte is not acknowledged and clears the register-write-enable latch. A following field byte is then refused.
- R10: Read transactions placed between the unlock steps do not disturb the sequence.
- R11: ack_vld_o pulses for exactly the one cycle after each address phase or write data byte.
- R12: Data bytes for a non-control target are acknowledged when wp_i is low and refused when it is high. They never change the stored bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; also resets the stored bits |
| rst_n | input | 1 | Soft reset, active low, synchronous; clears latches and the sequencer only |
| addr_vld_i | input | 1 | One-cycle pulse: an address phase has been received |
| addr_rd_i | input | 1 | Direction of the address phase (1 = read) |
| addr_ctrl_i | input | 1 | The address phase targets the control register |
| data_vld_i | input | 1 | One-cycle pulse: a complete write data byte has been received |
| data_i | input | 8 | The data byte |
| stop_i | input | 1 | One-cycle pulse: stop condition |
| wp_i | input | 1 | Write protect, active high |
| tick_i | input | 1 | Timing tick for the update duration |
| wd_o | output | 2 | Stored watchdog period field |
| pup_o | output | 2 | Stored power-up delay field |
| busy_o | output | 1 | Nonvolatile update in progress |
| ack_vld_o | output | 1 | An acknowledge decision is presented this cycle |
| ack_o | output | 1 | 1 = acknowledge, 0 = no acknowledge |

## Verification
The two enable latches cannot be seen directly at the ports. Each latch shows up only in the acknowledge answer to the next data byte, and in whether a later field byte changes wd_o and pup_o.

A wrong latch state therefore appears one cycle after the next data byte, as a flipped ack_o. It can also appear one cycle after the next stop, as a change (or a missing change) in wd_o, pup_o or busy_o. The directed scenarios are built so that each latch hazard is followed straight away by a byte that exposes it: a refused field byte after write protect, and a nack after a soft reset. A timer that is off by one shows up as busy_o still high, or already low, around the final tick.

// File: rtl/ctrl_guard_pkg.sv
package ctrl_guard_pkg;

    localparam int BYTE_W  = 8;
    localparam int FIELD_W = 2;

    localparam logic [BYTE_W-1:0] CODE_WEL  = 8'h02;
    localparam logic [BYTE_W-1:0] CODE_BOTH = 8'h06;
    localparam logic [BYTE_W-1:0] CODE_CLR  = 8'h00;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL_W,
        ST_HOLD,
        ST_ABORT,
        ST_MEM_W,
        ST_READ,
        ST_NV_BUSY
    } cg_state_e;

    typedef enum logic [2:0] {
        ACT_REJECT,
        ACT_SET_WEL,
        ACT_CLR_WEL,
        ACT_SET_RWEL,
        ACT_COMMIT,
        ACT_KEEP
    } cg_act_e;

endpackage

// File: rtl/ctrl_guard_classify.sv
module ctrl_guard_classify
    import ctrl_guard_pkg::*;
(
    input  logic [BYTE_W-1:0] data_i,
    input  logic              wel_i,
    input  logic              rwel_i,
    output cg_act_e           act_o
);

    logic frame_ok;

    // fixed positions of a field byte: bits 4..3 zero, bit 1 one
    assign frame_ok = (data_i[4:3] == 2'b00) && data_i[1];

    always_comb begin
        act_o = ACT_REJECT;
        if (rwel_i) begin
            if (frame_ok) begin
                act_o = data_i[2] ? ACT_KEEP : ACT_COMMIT;
            end
        end else if (data_i == CODE_WEL) begin
            act_o = ACT_SET_WEL;
        end else if (wel_i && data_i == CODE_BOTH) begin
            act_o = ACT_SET_RWEL;
        end else if (wel_i && data_i == CODE_CLR) begin
            act_o = ACT_CLR_WEL;
        end
    end

endmodule

// File: rtl/ctrl_guard_nv_timer.sv
module ctrl_guard_nv_timer #(
    parameter int NV_TICKS = 10
) (
    input  logic clk,
    input  logic por_n,
    input  logic clear_i,
    input  logic run_i,
    input  logic tick_i,
    output logic done_o
);

    localparam int CNT_W = (NV_TICKS < 2) ? 1 : $clog2(NV_TICKS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NV_TICKS - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (run_i && tick_i && cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done_o = run_i && tick_i && (cnt_q == LAST);

    // R8
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!por_n || clear_i)
        (!run_i || !tick_i) |=> $stable(cnt_q));

endmodule

// File: rtl/ctrl_guard_seq.sv
module ctrl_guard_seq
    import ctrl_guard_pkg::*;
#(
    parameter int               NV_TICKS  = 10,
    parameter logic [FIELD_W-1:0] WD_INIT  = 2'b11,
    parameter logic [FIELD_W-1:0] PUP_INIT = 2'b01
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               rst_n,
    input  logic               addr_vld_i,
    input  logic               addr_rd_i,
    input  logic               addr_ctrl_i,
    input  logic               data_vld_i,
    input  logic [BYTE_W-1:0]  data_i,
    input  logic               stop_i,
    input  logic               wp_i,
    input  logic               tick_i,
    output logic [FIELD_W-1:0] wd_o,
    output logic [FIELD_W-1:0] pup_o,
    output logic               busy_o,
    output logic               ack_vld_o,
    output logic               ack_o
);

    cg_state_e          state_q, state_d;
    cg_act_e            act, pend_q;
    logic               wel_q, rwel_q;
    logic [FIELD_W-1:0] wd_q, pup_q;
    logic               ack_vld_q, ack_q;
    logic               data_evt, stop_evt, commit_evt, data_ok, wp_hit;
    logic               in_txn, nv_done;

    ctrl_guard_classify u_classify (
        .data_i (data_i),
        .wel_i  (wel_q),
        .rwel_i (rwel_q),
        .act_o  (act)
    );

    ctrl_guard_nv_timer #(.NV_TICKS(NV_TICKS)) u_timer (
        .clk     (clk),
        .por_n   (por_n),
        .clear_i (commit_evt || !rst_n),
        .run_i   (state_q == ST_NV_BUSY),
        .tick_i  (tick_i),
        .done_o  (nv_done)
    );

    assign in_txn     = (state_q != ST_NV_BUSY);
    assign stop_evt   = stop_i && !addr_vld_i && in_txn;
    assign data_evt   = data_vld_i && !addr_vld_i && !stop_i;
    assign data_ok    = (act != ACT_REJECT) && !wp_i;
    assign commit_evt = rst_n && stop_evt && (state_q == ST_HOLD);
    assign wp_hit     = data_evt && wp_i &&
                        (state_q == ST_CTRL_W || state_q == ST_HOLD || state_q == ST_MEM_W);

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= ST_IDLE;
        end else if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_NV_BUSY: begin
                if (nv_done) begin
                    state_d = ST_IDLE;
                end
            end
            ST_IDLE, ST_CTRL_W, ST_HOLD, ST_ABORT, ST_MEM_W, ST_READ: begin
                if (addr_vld_i) begin
                    if (addr_rd_i) begin
                        state_d = ST_READ;
                    end else if (addr_ctrl_i) begin
                        state_d = ST_CTRL_W;
                    end else begin
                        state_d = ST_MEM_W;
                    end
                end else if (stop_i) begin
                    if (state_q == ST_HOLD && pend_q == ACT_COMMIT) begin
                        state_d = ST_NV_BUSY;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end else if (data_vld_i) begin
                    if (state_q == ST_CTRL_W) begin
                        state_d = data_ok ? ST_HOLD : ST_ABORT;
                    end else if (state_q == ST_HOLD) begin
                        state_d = ST_ABORT;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // pending action captured with the single accepted byte
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            pend_q <= ACT_REJECT;
        end else if (!rst_n) begin
            pend_q <= ACT_REJECT;
        end else if (data_evt && state_q == ST_CTRL_W) begin
            pend_q <= data_ok ? act : ACT_REJECT;
        end
    end

    // volatile enable latches
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            wel_q  <= 1'b0;
            rwel_q <= 1'b0;
        end else if (!rst_n) begin
            wel_q  <= 1'b0;
            rwel_q <= 1'b0;
        end else if (commit_evt) begin
            unique case (pend_q)
                ACT_SET_WEL:  wel_q <= 1'b1;
                ACT_CLR_WEL:  wel_q <= 1'b0;
                ACT_SET_RWEL: begin
                    wel_q  <= 1'b1;
                    rwel_q <= 1'b1;
                end
                ACT_COMMIT:   rwel_q <= 1'b0;
                ACT_KEEP, ACT_REJECT: begin
                end
                default: begin
                end
            endcase
        end else if (wp_hit) begin
            rwel_q <= 1'b0;
        end
    end

    // stored control fields, power-on reset only
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            wd_q  <= WD_INIT;
            pup_q <= PUP_INIT;
        end else if (commit_evt && pend_q == ACT_COMMIT) begin
            wd_q  <= data_hold_wd(hold_byte_q);
            pup_q <= data_hold_pup(hold_byte_q);
        end
    end

    logic [BYTE_W-1:0] hold_byte_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            hold_byte_q <= '0;
        end else if (data_evt && state_q == ST_CTRL_W) begin
            hold_byte_q <= data_i;
        end
    end

    function automatic logic [FIELD_W-1:0] data_hold_wd(input logic [BYTE_W-1:0] b);
        return {b[6], b[5]};
    endfunction

    function automatic logic [FIELD_W-1:0] data_hold_pup(input logic [BYTE_W-1:0] b);
        return {b[7], b[0]};
    endfunction

    // acknowledge outputs
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            ack_vld_q <= 1'b0;
            ack_q     <= 1'b0;
        end else if (!rst_n) begin
            ack_vld_q <= 1'b0;
            ack_q     <= 1'b0;
        end else begin
            ack_vld_q <= 1'b0;
            ack_q     <= 1'b0;
            if (addr_vld_i) begin
                ack_vld_q <= 1'b1;
                ack_q     <= in_txn;
            end else if (data_evt) begin
                unique case (state_q)
                    ST_CTRL_W: begin
                        ack_vld_q <= 1'b1;
                        ack_q     <= data_ok;
                    end
                    ST_HOLD, ST_ABORT: begin
                        ack_vld_q <= 1'b1;
                        ack_q     <= 1'b0;
                    end
                    ST_MEM_W: begin
                        ack_vld_q <= 1'b1;
                        ack_q     <= !wp_i;
                    end
                    ST_IDLE, ST_READ, ST_NV_BUSY: begin
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

    assign wd_o      = wd_q;
    assign pup_o     = pup_q;
    assign busy_o    = (state_q == ST_NV_BUSY);
    assign ack_vld_o = ack_vld_q;
    assign ack_o     = ack_q;

    // R8
    busy_addr_nack_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (addr_vld_i && busy_o) |=> (ack_vld_o && !ack_o));

    // R9
    wp_data_nack_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        wp_hit |=> (ack_vld_o && !ack_o && !rwel_q));

    // R4
    field_change_busy_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        !$stable({wd_o, pup_o}) |-> busy_o);

    // R5
    rwel_needs_wel_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        rwel_q |-> wel_q);

    // R6
    second_byte_nack_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (data_evt && state_q == ST_HOLD) |=> (ack_vld_o && !ack_o && state_q == ST_ABORT));

    // R11
    ack_source_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        ack_vld_o |-> $past(addr_vld_i || data_vld_i));

endmodule

// File: tb/ctrl_guard_seq_tb.sv
module ctrl_guard_seq_tb;

    logic       clk = 1'b0;
    logic       por_n = 1'b0, rst_n = 1'b0;
    logic       addr_vld = 1'b0, addr_rd = 1'b0, addr_ctrl = 1'b0;
    logic       data_vld = 1'b0, stop = 1'b0, wp = 1'b0, tick = 1'b0;
    logic [7:0] data = 8'h00;
    logic [1:0] wd, pup;
    logic       busy, ack_vld, ack;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    ctrl_guard_seq #(.NV_TICKS(10)) u_dut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n),
        .addr_vld_i(addr_vld), .addr_rd_i(addr_rd), .addr_ctrl_i(addr_ctrl),
        .data_vld_i(data_vld), .data_i(data), .stop_i(stop), .wp_i(wp),
        .tick_i(tick), .wd_o(wd), .pup_o(pup), .busy_o(busy),
        .ack_vld_o(ack_vld), .ack_o(ack)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_addr(input bit rd, input bit ctl, output bit a);
        @(negedge clk);
        addr_vld = 1'b1; addr_rd = rd; addr_ctrl = ctl;
        @(negedge clk);
        addr_vld = 1'b0;
        check("R11 addr ack_vld", ack_vld, 1);
        a = ack;
        @(negedge clk);
        check("R11 ack_vld one cycle", ack_vld, 0);
    endtask

    task automatic send_data(input logic [7:0] b, output bit a);
        @(negedge clk);
        data_vld = 1'b1; data = b;
        @(negedge clk);
        data_vld = 1'b0;
        check("R11 data ack_vld", ack_vld, 1);
        a = ack;
    endtask

    task automatic send_stop();
        @(negedge clk);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic ctrl_wr(input logic [7:0] b, output bit a);
        bit x;
        send_addr(1'b0, 1'b1, x);
        send_data(b, a);
        send_stop();
    endtask

    task automatic unlock();
        bit a;
        ctrl_wr(8'h02, a);
        check("R3 02h acked", a, 1);
        ctrl_wr(8'h06, a);
        check("R4 06h acked", a, 1);
    endtask

    task automatic check_fields(input string req, input int ewd, input int epup);
        check({req, " wd"}, wd, ewd);
        check({req, " pup"}, pup, epup);
    endtask

    task automatic wait_nv();
        bit a;
        check("R8 busy after commit", busy, 1);
        send_addr(1'b0, 1'b1, a);
        check("R8 address nacked while busy", a, 0);
        for (int i = 0; i < 9; i++) pulse_tick();
        check("R8 busy before last tick", busy, 1);
        pulse_tick();
        check("R8 busy released", busy, 0);
        send_addr(1'b0, 1'b1, a);
        check("R8 address acked after", a, 1);
        send_stop();
    endtask

    task automatic t_power_on();
        bit a;
        check_fields("R1 reset", 2'b11, 2'b01);
        check("R1 busy", busy, 0);
        check("R1 ack_vld idle", ack_vld, 0);
        ctrl_wr(8'h06, a);
        check("R3 06h nacked with latch clear", a, 0);
        check_fields("R3 no effect", 2'b11, 2'b01);
    endtask

    task automatic t_layout();
        bit a;
        unlock();
        ctrl_wr(8'hA3, a);
        check("R4 field byte acked", a, 1);
        check_fields("R4 A3h", 2'b01, 2'b11);
        wait_nv();
        unlock();
        ctrl_wr(8'h43, a);
        check_fields("R4 43h", 2'b10, 2'b01);
        wait_nv();
    endtask

    task automatic t_keep();
        bit a;
        unlock();
        ctrl_wr(8'h06, a);
        check("R5 keep byte acked", a, 1);
        check("R5 keep not busy", busy, 0);
        check_fields("R5 keep", 2'b10, 2'b01);
        ctrl_wr(8'h02, a);
        check("R5 02h after keep acked", a, 1);
        check_fields("R5 zeroed", 2'b00, 2'b00);
        wait_nv();
    endtask

    task automatic t_second_and_soft();
        bit a;
        unlock();
        send_addr(1'b0, 1'b1, a);
        send_data(8'h23, a);
        check("R6 first byte acked", a, 1);
        send_data(8'h00, a);
        check("R6 second byte nacked", a, 0);
        send_stop();
        check("R6 not busy", busy, 0);
        check_fields("R6 unchanged", 2'b00, 2'b00);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check_fields("R2 fields kept", 2'b00, 2'b00);
        ctrl_wr(8'h23, a);
        check("R2 latches cleared", a, 0);
        check("R2 not busy", busy, 0);
    endtask

    task automatic t_early_stop();
        bit a;
        unlock();
        send_addr(1'b0, 1'b1, a);
        send_stop();
        check("R7 not busy", busy, 0);
        check_fields("R7 unchanged", 2'b00, 2'b00);
        ctrl_wr(8'h63, a);
        check("R7 unlock survived", a, 1);
        check_fields("R7 63h", 2'b11, 2'b01);
        wait_nv();
    endtask

    task automatic t_reads();
        bit a;
        ctrl_wr(8'h02, a);
        send_addr(1'b1, 1'b1, a);
        send_stop();
        ctrl_wr(8'h06, a);
        check("R10 06h after read", a, 1);
        send_addr(1'b1, 1'b1, a);
        send_stop();
        ctrl_wr(8'hA2, a);
        check("R10 field acked", a, 1);
        check_fields("R10 A2h", 2'b01, 2'b10);
        wait_nv();
    endtask

    task automatic t_protect();
        bit a;
        unlock();
        wp = 1'b1;
        ctrl_wr(8'h63, a);
        check("R9 protected nacked", a, 0);
        wp = 1'b0;
        ctrl_wr(8'h63, a);
        check("R9 latch cleared", a, 0);
        check("R9 not busy", busy, 0);
        check_fields("R9 unchanged", 2'b01, 2'b10);
    endtask

    task automatic t_other_target();
        bit a;
        send_addr(1'b0, 1'b0, a);
        send_data(8'h55, a);
        check("R12 other target acked", a, 1);
        wp = 1'b1;
        send_data(8'h55, a);
        check("R12 other target protected", a, 0);
        wp = 1'b0;
        send_stop();
        check_fields("R12 unchanged", 2'b01, 2'b10);
        check("R12 not busy", busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        rst_n = 1'b1;
        @(negedge clk);
        t_power_on();
        t_layout();
        t_keep();
        t_second_and_soft();
        t_early_stop();
        t_reads();
        t_protect();
        t_other_target();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule